// File: doc/BRIEF.md
# Ping-Pong Overhead Channel Capture

This block gathers the nine line data-channel overhead bytes that arrive in every frame and assembles them into multi-frame messages. Bytes are packed two to a 16-bit word and written into one of two register banks. When a message of 24 frames (216 bytes, 108 words) is complete, the two banks trade roles. The processor then reads a finished message from one bank while the next message fills the other. The processor therefore gets one interrupt per message rather than one per byte, and has a full message period to read the bank.

An upstream framer supplies the byte stream, a strobe that marks data-channel bytes and a frame-start pulse. A separate alarm detector supplies four alarm inputs: loss of signal, loss of frame, severely errored frame and line AIS. While any alarm is active, collection stops. When all alarms clear, collection restarts on a clean frame boundary. A sticky status flag with write-one-to-clear, a mask register and an interrupt line report each completed message.

Top module: `ohc_capture`

## Requirements
- R1: After reset the status flag and the interrupt are 0, and every read address returns 0.
- R2: Accepted bytes pack in pairs, in arrival order across frame boundaries. Word k of a message holds message byte 2k in bits [15:8] and byte 2k+1 in bits [7:0].
- R3: Once the 216th byte of a message is accepted (the ninth byte of its 24th frame), the completed message can be read at word addresses 0 to 107. Bytes accepted for the following message do not change what the read port returns.
- R4: The status flag sets on every bank swap and stays set until a one is written to it through the clear input. When a swap and a clear fall in the same cycle, the flag ends up set.
- R5: The interrupt is 1 exactly when the status flag is 1 and the mask bit is 0. The mask bit is written through a write-enable and a data input, and resets to 1 (masked).
- R6: While any of the four alarm inputs is 1, strobed bytes and frame starts are ignored. The partial message is discarded and no swap occurs. Collection resumes at the first frame start after all alarms are 0, beginning an empty message.
- R7: Within a frame, strobes after the ninth accepted byte are ignored, and so is a strobe in the same cycle as a frame start.
- R8: A read address of 108 or above returns 0.
- R9: Consecutive messages alternate between the two banks, so after the second swap the read port shows the second message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| oh_byte | input | 8 | Overhead byte stream |
| dcc_stb | input | 1 | Marks the current byte as a data-channel byte |
| frame_sop | input | 1 | One-cycle frame-start pulse |
| alm_los | input | 1 | Loss-of-signal alarm |
| alm_lof | input | 1 | Loss-of-frame alarm |
| alm_sef | input | 1 | Severely-errored-frame alarm |
| alm_ais | input | 1 | Line AIS alarm |
| rd_addr | input | 7 | Processor word address into the read bank |
| rd_data | output | 16 | Word read from the read bank (combinational) |
| stat_w1c | input | 1 | Write-one pulse that clears the status flag |
| mask_we | input | 1 | Mask register write enable |
| mask_wdata | input | 1 | Value written to the mask register |
| stat_flag | output | 1 | Sticky message-complete flag |
| mask_flag | output | 1 | Current mask bit |
| irq | output | 1 | Interrupt request |

## Verification
The hardest conditions to reach from the ports are those tied to one exact cycle. One is a clear pulse landing in the same cycle as the final byte of a message. Another is an alarm that interrupts a message part-way, followed by enough frames to complete a message had the alarm been ignored. The bench drives frames with random byte values and random idle gaps between strobes. A frame task can raise the clear pulse alongside the 216th byte, and can inject junk strobes on the frame-start cycle and after the ninth byte. For each of the four alarms in turn, the bench sends a partial message, holds the alarm through the rest of the frames, and confirms that neither the read bank nor the flag changed before a fresh message completes.

// File: rtl/ohc_pkg.sv
// Package: shared constants and types for the overhead channel capture.
// Assumes an 8-bit byte stream; the word width is twice the byte width.
package ohc_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    // Bundle of the four alarm inputs that gate collection.
    typedef struct packed {
        logic los;
        logic lof;
        logic sef;
        logic ais;
    } ohc_alarm_t;
endpackage

// File: rtl/ohc_collect.sv
// Collector: tracks frame and byte position, packs accepted bytes into words,
// issues bank writes and a one-cycle swap pulse when a message completes.
// Assumes BPF*FRAMES is even, that frame starts are one-cycle pulses and that
// strobes only mark data-channel bytes.
module ohc_collect
    import ohc_pkg::*;
#(
    parameter int BPF    = 9,
    parameter int FRAMES = 24,
    localparam int MSG_BYTES = BPF * FRAMES,
    localparam int PW = $clog2(MSG_BYTES),
    localparam int AW = PW - 1,
    localparam int FW = (FRAMES > 1) ? $clog2(FRAMES) : 1,
    localparam int BW = $clog2(BPF + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              stb_i,
    input  logic              sop_i,
    input  ohc_alarm_t        alarm_i,
    output logic              wr_en_o,
    output logic [AW-1:0]     wr_addr_o,
    output logic [WORD_W-1:0] wr_data_o,
    output logic              wr_sel_o,
    output logic              swap_o
);
    logic              active;
    logic [FW-1:0]     frm_idx;
    logic [BW-1:0]     byte_idx;
    logic [PW-1:0]     msg_pos;
    logic [BYTE_W-1:0] hi_q;
    logic              wr_sel;
    logic              alarm_any;
    logic              take;

    // Any alarm suspends collection.
    assign alarm_any = |alarm_i;

    // A byte is taken when collecting, strobed, not on a frame start and within the per-frame cap.
    always_comb begin
        take = active && !alarm_any && !sop_i && stb_i && (byte_idx < BW'(BPF));
    end

    // Swap on the last byte of the message; odd positions complete a word.
    assign swap_o    = take && (msg_pos == PW'(MSG_BYTES - 1));
    assign wr_en_o   = take && msg_pos[0];
    assign wr_addr_o = msg_pos[PW-1:1];
    assign wr_data_o = {hi_q, byte_i};
    assign wr_sel_o  = wr_sel;

    // Position tracking, alarm handling and message restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            frm_idx  <= '0;
            byte_idx <= '0;
            msg_pos  <= '0;
        end else if (alarm_any) begin
            active   <= 1'b0;
            frm_idx  <= '0;
            byte_idx <= '0;
            msg_pos  <= '0;
        end else if (sop_i) begin
            byte_idx <= '0;
            if (!active || frm_idx == FW'(FRAMES - 1)) begin
                active  <= 1'b1;
                frm_idx <= '0;
                msg_pos <= '0;
            end else begin
                frm_idx <= frm_idx + 1'b1;
            end
        end else if (take) begin
            byte_idx <= byte_idx + 1'b1;
            msg_pos  <= swap_o ? '0 : msg_pos + 1'b1;
        end
    end

    // Hold the first byte of each pair until its partner arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
        end else if (take && !msg_pos[0]) begin
            hi_q <= byte_i;
        end
    end

    // Write-bank select; 0 means bank A is written after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_sel <= 1'b0;
        end else if (swap_o) begin
            wr_sel <= ~wr_sel;
        end
    end

    AST_SWAP_LAST_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        swap_o |-> (frm_idx == FW'(FRAMES - 1))); // R3
    AST_BYTE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        byte_idx <= BW'(BPF)); // R7
    AST_ALARM_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_any |=> !wr_en_o || !active); // R6
    AST_SOP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        sop_i |-> !wr_en_o); // R7
endmodule

// File: rtl/ohc_bank.sv
// Bank: one word-addressed register array with a synchronous write port and
// a combinational read port. Out-of-range read addresses return zero.
// Assumes the writer never addresses beyond DEPTH-1.
module ohc_bank #(
    parameter int DEPTH = 108,
    parameter int WIDTH = 16,
    parameter int AW    = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    // Clear on reset, otherwise store the incoming word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Read with range guard.
    always_comb begin
        rdata = '0;
        if (int'(raddr) < DEPTH) begin
            rdata = mem[raddr];
        end
    end

    AST_WADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (int'(waddr) < DEPTH)); // R3
endmodule

// File: rtl/ohc_status.sv
// Status: sticky message-complete flag with write-one-to-clear, a mask bit and
// the interrupt output. A swap in the same cycle as a clear keeps the flag set.
module ohc_status (
    input  logic clk,
    input  logic rst_n,
    input  logic swap_i,
    input  logic clr_i,
    input  logic mask_we_i,
    input  logic mask_d_i,
    output logic stat_o,
    output logic mask_o,
    output logic irq_o
);
    // Sticky flag: set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_o <= 1'b0;
        end else if (swap_i) begin
            stat_o <= 1'b1;
        end else if (clr_i) begin
            stat_o <= 1'b0;
        end
    end

    // Mask register, masked out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_o <= 1'b1;
        end else if (mask_we_i) begin
            mask_o <= mask_d_i;
        end
    end

    // Interrupt request.
    assign irq_o = stat_o & ~mask_o;

    AST_SWAP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        swap_i |=> stat_o); // R4
    AST_STAT_FALL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_o) |-> $past(clr_i)); // R4
    AST_IRQ_HAS_STAT: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> stat_o); // R5
endmodule

// File: rtl/ohc_capture.sv
// Top: ping-pong capture of per-frame data-channel overhead bytes into two
// banks, with processor read port, sticky status, mask and interrupt.
// Assumes frame alignment, byte-position decoding and alarm detection upstream.
module ohc_capture
    import ohc_pkg::*;
#(
    parameter int BPF    = 9,
    parameter int FRAMES = 24,
    localparam int WORDS = (BPF * FRAMES) / 2,
    localparam int AW    = $clog2(BPF * FRAMES) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] oh_byte,
    input  logic              dcc_stb,
    input  logic              frame_sop,
    input  logic              alm_los,
    input  logic              alm_lof,
    input  logic              alm_sef,
    input  logic              alm_ais,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_data,
    input  logic              stat_w1c,
    input  logic              mask_we,
    input  logic              mask_wdata,
    output logic              stat_flag,
    output logic              mask_flag,
    output logic              irq
);
    ohc_alarm_t        alarms;
    logic              wr_en;
    logic [AW-1:0]     wr_addr;
    logic [WORD_W-1:0] wr_data;
    logic              wr_sel;
    logic              swap;
    logic [WORD_W-1:0] bank_rd [2];

    // Gather alarms into one bundle.
    assign alarms = '{los: alm_los, lof: alm_lof, sef: alm_sef, ais: alm_ais};

    ohc_collect #(.BPF(BPF), .FRAMES(FRAMES)) collect_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_i   (oh_byte),
        .stb_i    (dcc_stb),
        .sop_i    (frame_sop),
        .alarm_i  (alarms),
        .wr_en_o  (wr_en),
        .wr_addr_o(wr_addr),
        .wr_data_o(wr_data),
        .wr_sel_o (wr_sel),
        .swap_o   (swap)
    );

    for (genvar b = 0; b < 2; b++) begin : g_bank
        ohc_bank #(.DEPTH(WORDS), .WIDTH(WORD_W), .AW(AW)) bank_i (
            .clk  (clk),
            .rst_n(rst_n),
            .we   (wr_en && (wr_sel == 1'(b))),
            .waddr(wr_addr),
            .wdata(wr_data),
            .raddr(rd_addr),
            .rdata(bank_rd[b])
        );
    end

    // Processor always reads the bank that is not being written.
    assign rd_data = wr_sel ? bank_rd[0] : bank_rd[1];

    ohc_status status_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .swap_i   (swap),
        .clr_i    (stat_w1c),
        .mask_we_i(mask_we),
        .mask_d_i (mask_wdata),
        .stat_o   (stat_flag),
        .mask_o   (mask_flag),
        .irq_o    (irq)
    );

    AST_BANK_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        swap |=> (wr_sel != $past(wr_sel))); // R9
endmodule

// File: tb/ohc_capture_tb.sv
module ohc_capture_tb_top;
    localparam int BPF = 9;
    localparam int FRAMES = 24;
    localparam int MSGB = BPF * FRAMES;
    localparam int WORDS = MSGB / 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  oh_byte = '0;
    logic        dcc_stb = 1'b0, frame_sop = 1'b0;
    logic        alm_los = 1'b0, alm_lof = 1'b0, alm_sef = 1'b0, alm_ais = 1'b0;
    logic [6:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        stat_w1c = 1'b0, mask_we = 1'b0, mask_wdata = 1'b0;
    logic        stat_flag, mask_flag, irq;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] cur [MSGB];
    logic [7:0] shown [MSGB];

    always #2 clk = ~clk;

    ohc_capture dut_i (
        .clk(clk), .rst_n(rst_n), .oh_byte(oh_byte), .dcc_stb(dcc_stb),
        .frame_sop(frame_sop), .alm_los(alm_los), .alm_lof(alm_lof),
        .alm_sef(alm_sef), .alm_ais(alm_ais), .rd_addr(rd_addr),
        .rd_data(rd_data), .stat_w1c(stat_w1c), .mask_we(mask_we),
        .mask_wdata(mask_wdata), .stat_flag(stat_flag),
        .mask_flag(mask_flag), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_word(input int k, input logic [7:0] m [MSGB]);
        return {m[2*k], m[2*k+1]};
    endfunction

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Compare every read-bank word against a byte message.
    task automatic check_bank(input string req, input logic [7:0] m [MSGB]);
        for (int k = 0; k < WORDS; k++) begin
            rd_addr = 7'(k);
            #1;
            chk(rd_data == exp_word(k, m), req, int'(rd_data), int'(exp_word(k, m)));
        end
        rd_addr = '0;
    endtask

    task automatic fill_cur();
        for (int i = 0; i < MSGB; i++) cur[i] = 8'($urandom);
    endtask

    // One frame of cur: start pulse, nine strobed bytes with random gaps.
    task automatic send_frame(input int f, input bit junk, input bit clr_last);
        frame_sop = 1'b1;
        dcc_stb = junk;
        oh_byte = 8'($urandom);
        @(negedge clk);
        frame_sop = 1'b0;
        dcc_stb = 1'b0;
        for (int k = 0; k < BPF; k++) begin
            repeat ($urandom % 3) @(negedge clk);
            oh_byte = cur[f*BPF + k];
            dcc_stb = 1'b1;
            if (clr_last && f == FRAMES-1 && k == BPF-1) stat_w1c = 1'b1;
            @(negedge clk);
            dcc_stb = 1'b0;
            stat_w1c = 1'b0;
        end
        if (junk) begin
            for (int j = 0; j < 2; j++) begin
                oh_byte = 8'($urandom);
                dcc_stb = 1'b1;
                @(negedge clk);
            end
            dcc_stb = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic send_frames(input int lo, input int hi, input bit junk, input bit clr_last);
        for (int f = lo; f <= hi; f++) send_frame(f, junk && (f % 5 == 2), clr_last);
    endtask

    task automatic pulse_clear();
        stat_w1c = 1'b1;
        @(negedge clk);
        stat_w1c = 1'b0;
        #1;
    endtask

    task automatic set_mask(input logic v);
        mask_we = 1'b1;
        mask_wdata = v;
        @(negedge clk);
        mask_we = 1'b0;
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < MSGB; i++) shown[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(stat_flag == 1'b0, "R1 stat", int'(stat_flag), 0);
        chk(irq == 1'b0, "R1 irq", int'(irq), 0);
        chk(mask_flag == 1'b1, "R5 mask reset", int'(mask_flag), 1);
        check_bank("R1 read zero", shown);

        // R2/R3: first message, random gaps
        fill_cur();
        send_frames(0, FRAMES-1, 1'b0, 1'b0);
        #1;
        chk(stat_flag == 1'b1, "R4 set on swap", int'(stat_flag), 1);
        chk(irq == 1'b0, "R5 masked irq", int'(irq), 0);
        shown = cur;
        check_bank("R2 R3 message one", shown);
        rd_addr = 7'd108; #1;
        chk(rd_data == 16'h0, "R8 addr 108", int'(rd_data), 0);
        rd_addr = 7'd127; #1;
        chk(rd_data == 16'h0, "R8 addr 127", int'(rd_data), 0);
        rd_addr = '0;

        // R4 sticky, R5 mask
        repeat (20) @(negedge clk);
        #1;
        chk(stat_flag == 1'b1, "R4 sticky", int'(stat_flag), 1);
        set_mask(1'b0);
        chk(irq == 1'b1, "R5 irq unmasked", int'(irq), 1);
        set_mask(1'b1);
        chk(irq == 1'b0, "R5 irq remasked", int'(irq), 0);
        set_mask(1'b0);
        pulse_clear();
        chk(stat_flag == 1'b0, "R4 w1c", int'(stat_flag), 0);
        chk(irq == 1'b0, "R5 irq after clear", int'(irq), 0);

        // R3/R7/R9: second message with junk strobes, read bank held mid-way
        fill_cur();
        send_frames(0, 11, 1'b1, 1'b0);
        check_bank("R3 read bank held", shown);
        chk(stat_flag == 1'b0, "R3 no early swap", int'(stat_flag), 0);
        // R4: clear coincides with the final byte, swap wins
        send_frames(12, FRAMES-1, 1'b1, 1'b1);
        #1;
        chk(stat_flag == 1'b1, "R4 swap beats clear", int'(stat_flag), 1);
        chk(irq == 1'b1, "R5 irq on swap", int'(irq), 1);
        shown = cur;
        check_bank("R7 R9 message two", shown);

        // R6: each alarm discards a partial message
        for (int a = 0; a < 4; a++) begin
            pulse_clear();
            fill_cur();
            send_frames(0, 9, 1'b0, 1'b0);
            {alm_ais, alm_sef, alm_lof, alm_los} = 4'(1 << a);
            send_frames(10, FRAMES-1, 1'b0, 1'b0);
            #1;
            chk(stat_flag == 1'b0, "R6 no swap under alarm", int'(stat_flag), 0);
            check_bank("R6 bank unchanged", shown);
            {alm_ais, alm_sef, alm_lof, alm_los} = 4'b0;
            @(negedge clk);
            fill_cur();
            send_frames(0, FRAMES-1, 1'b0, 1'b0);
            #1;
            chk(stat_flag == 1'b1, "R6 resume swap", int'(stat_flag), 1);
            shown = cur;
            check_bank("R6 fresh message", shown);
        end
        summary();
    end
endmodule